// File: doc/BRIEF.md
# Inbound Aperture Address Translator with Lane Swap

This block sits on the inbound side of a bus bridge. A host-bus access that has already been found to fall inside a memory or I/O aperture arrives as one request beat. The block turns the host address into a local-bus address and rearranges the byte lanes of the 32-bit write data and its byte enables. Both results leave one clock later, registered together with the direction bit. Returning read data goes through the same lane permutation on its way back.

A single map register controls the translation. It holds a base field, an aperture size code, a swap mode and a flag that suppresses a retry on the first read of a burst. The size code sets how many upper address bits come from the base field; the rest come from the host address. A reserved size code falls back to the smallest memory aperture and raises `cfg_error`. The swap mode can be fixed, or automatic, in which case the active byte-enable pattern chooses the swap.

Top module: `apx_inbound_xlate`

## Requirements
- R1: After reset the map register holds all zeroes. `loc_valid` is 0 and `cfg_error` is 0. A request then maps with base 0 into a 1MB aperture, has no swap applied, and reports `retry_ok`=1.
- R2: `loc_valid` equals `req_valid` one cycle later. `loc_addr`, `loc_be`, `loc_wdata`, `loc_wr` and `retry_ok` all describe that same request.
- R3: The map word is `cfg_wdata[30:7]`=base (local address bits 31:8), `[6:3]`=size code, `[2:1]`=swap mode and `[0]`=read-post-disable. For a memory request with size code c in 0..10, let k=20+c. Then `loc_addr[31:k]` is taken from the base and `loc_addr[k-1:2]` from `req_addr`.
- R4: For an I/O request (`req_io`=1), size codes 4..7 give k=c+4 (256B to 2KB apertures), and the mapping is otherwise as in R3. Any other valid code uses the memory mapping.
- R5: Size codes 11..15 are reserved. They map as k=20, and `cfg_error` is 1 while such a code is held. `cfg_error` is 0 for codes 0..10.
- R6: `loc_addr[1:0]` is always 0.
- R7: Swap mode 00 passes the data and byte enables unchanged.
- R8: Swap mode 01 exchanges the 16-bit halves: out[31:16]=in[15:0] and out[15:0]=in[31:16]. The byte-enable bits move with their lanes.
- R9: Swap mode 10 reverses the byte order: out[31:24]=in[7:0], out[23:16]=in[15:8], out[15:8]=in[23:16] and out[7:0]=in[31:24]. The byte enables are bit-reversed to match.
- R10: Swap mode 11 picks the swap from `req_be`. The patterns 1100 and 0011 select the R8 swap. The patterns 1110, 1101, 1011 and 0111 select the R9 swap. Every other pattern selects no swap.
- R11: `retry_ok` is 0 for a read (`req_wr`=0) marked `req_first` while read-post-disable is 1. It is 1 for every other request.
- R12: `hst_rdata` is `lcl_rdata` permuted by the current swap mode. In automatic mode the byte enables of the last accepted request choose the swap.
- R13: A map write takes effect for requests sampled on the next clock edge. A request sampled in the same cycle as the write uses the old map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Map register write strobe |
| cfg_wdata | input | 31 | Map register write value |
| cfg_error | output | 1 | Map holds a reserved size code |
| req_valid | input | 1 | Request beat present |
| req_io | input | 1 | Request hit an I/O aperture |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_first | input | 1 | First beat of a burst |
| req_addr | input | 32 | Host-bus address |
| req_be | input | 4 | Host byte enables |
| req_wdata | input | 32 | Host write data |
| loc_valid | output | 1 | Translated beat present |
| loc_wr | output | 1 | Registered direction |
| loc_addr | output | 32 | Local-bus address |
| loc_be | output | 4 | Swapped byte enables |
| loc_wdata | output | 32 | Swapped write data |
| retry_ok | output | 1 | A retry may be signalled for this beat |
| lcl_rdata | input | 32 | Local read data |
| hst_rdata | output | 32 | Swapped read data toward the host |

## Verification
The address path is tested with size codes at the small end, the middle and the top of the memory range, with I/O codes, and with reserved codes. The host address carries distinct bits on both sides of each boundary, and non-zero low bits, so an off-by-one in the split shows up in the result. Write data uses unique byte values, and the byte enables are asymmetric. This lets the half swap, the full reversal and the pass-through be told apart, and shows whether automatic mode decoded the right pattern class. The read-post-disable flag is crossed with read, write, first and later beats. Separate tests cover a map write landing in the same cycle as a request, and the read-return permutation.

// File: rtl/apx_pkg.sv
package apx_pkg;

   typedef enum logic [1:0] {
      SWP_NONE = 2'b00,
      SWP_HALF = 2'b01,
      SWP_BYTE = 2'b10,
      SWP_AUTO = 2'b11
   } swap_mode_e;

   // Turn the automatic setting into a concrete permutation from the lane enables
   function automatic swap_mode_e resolve_swap(swap_mode_e mode, logic [3:0] be);
      swap_mode_e eff;
      if (mode != SWP_AUTO) begin
         eff = mode;
      end else begin
         case (be)
            4'b1100, 4'b0011:                   eff = SWP_HALF;
            4'b1110, 4'b1101, 4'b1011, 4'b0111: eff = SWP_BYTE;
            default:                            eff = SWP_NONE;
         endcase
      end
      return eff;
   endfunction

endpackage

// File: rtl/apx_map_reg.sv
module apx_map_reg
   import apx_pkg::*;
#(
   parameter int unsigned BASE_W = 24,
   parameter int unsigned SIZE_W = 4,
   localparam int unsigned CFG_W = BASE_W + SIZE_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CFG_W-1:0]  wdata,
   output logic [BASE_W-1:0] base_o,
   output logic [SIZE_W-1:0] size_o,
   output swap_mode_e        swap_o,
   output logic              rpd_o
);
   localparam int unsigned RPD_BIT  = 0;
   localparam int unsigned SWAP_LSB = 1;
   localparam int unsigned SIZE_LSB = 3;
   localparam int unsigned BASE_LSB = SIZE_LSB + SIZE_W;

   if (BASE_LSB + BASE_W != CFG_W) begin : g_bad_layout
      $error("apx_map_reg: field layout does not fill the map word");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_o <= '0;
         size_o <= '0;
         swap_o <= SWP_NONE;
         rpd_o  <= 1'b0;
      end else if (we) begin
         base_o <= wdata[BASE_LSB +: BASE_W];
         size_o <= wdata[SIZE_LSB +: SIZE_W];
         swap_o <= swap_mode_e'(wdata[SWAP_LSB +: 2]);
         rpd_o  <= wdata[RPD_BIT];
      end
   end

endmodule

// File: rtl/apx_shift_dec.sv
module apx_shift_dec #(
   parameter int unsigned SIZE_W        = 4,
   parameter int unsigned SHW           = 6,
   parameter int unsigned MEM_MIN_SHIFT = 20,
   parameter int unsigned MEM_CODES     = 11,
   parameter int unsigned IO_MIN_SHIFT  = 8,
   parameter int unsigned IO_FIRST_CODE = 4,
   parameter int unsigned IO_CODES      = 4
) (
   input  logic [SIZE_W-1:0] size_i,
   input  logic              io_i,
   output logic [SHW-1:0]    shift_o,
   output logic              reserved_o
);
   localparam int unsigned IO_LAST_CODE = IO_FIRST_CODE + IO_CODES - 1;

   if (MEM_CODES > (1 << SIZE_W)) begin : g_bad_codes
      $error("apx_shift_dec: more memory codes than the size field can hold");
   end
   if (IO_LAST_CODE >= MEM_CODES) begin : g_bad_io
      $error("apx_shift_dec: I/O code window leaves the valid range");
   end

   logic io_code;

   always_comb begin
      reserved_o = (32'(size_i) >= MEM_CODES);
      io_code    = io_i && (32'(size_i) >= IO_FIRST_CODE) && (32'(size_i) <= IO_LAST_CODE);
      if (reserved_o) begin
         shift_o = SHW'(MEM_MIN_SHIFT);
      end else if (io_code) begin
         shift_o = SHW'(IO_MIN_SHIFT) + SHW'(size_i) - SHW'(IO_FIRST_CODE);
      end else begin
         shift_o = SHW'(MEM_MIN_SHIFT) + SHW'(size_i);
      end
   end

endmodule

// File: rtl/apx_addr_map.sv
module apx_addr_map #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned BASE_W = 24,
   parameter int unsigned SHW    = 6
) (
   input  logic [BASE_W-1:0] base_i,
   input  logic [SHW-1:0]    shift_i,
   input  logic [ADDR_W-1:0] host_i,
   output logic [ADDR_W-1:0] loc_o
);
   localparam int unsigned PAD_W = ADDR_W - BASE_W;

   if (BASE_W >= ADDR_W) begin : g_bad_base
      $error("apx_addr_map: base field must be narrower than the address");
   end

   logic [ADDR_W-1:0] base_full;
   assign base_full = {base_i, {PAD_W{1'b0}}};

   // word alignment: the byte offset is never forwarded
   assign loc_o[1:0] = host_i[1:0] & 2'b00;

   for (genvar i = 2; i < ADDR_W; i++) begin : g_bit
      assign loc_o[i] = (SHW'(i) >= shift_i) ? base_full[i] : host_i[i];
   end

endmodule

// File: rtl/apx_lane_swap.sv
module apx_lane_swap
   import apx_pkg::*;
#(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned LANES  = 4,
   localparam int unsigned TOT_W = LANE_W * LANES
) (
   input  swap_mode_e        mode_i,
   input  logic [TOT_W-1:0]  din,
   output logic [TOT_W-1:0]  dout
);
   if (LANES % 2 != 0) begin : g_bad_lanes
      $error("apx_lane_swap: lane count must be even");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int unsigned HALF_SRC = (i + LANES / 2) % LANES;
      localparam int unsigned REV_SRC  = LANES - 1 - i;
      always_comb begin
         case (mode_i)
            SWP_HALF: dout[i*LANE_W +: LANE_W] = din[HALF_SRC*LANE_W +: LANE_W];
            SWP_BYTE: dout[i*LANE_W +: LANE_W] = din[REV_SRC*LANE_W +: LANE_W];
            default:  dout[i*LANE_W +: LANE_W] = din[i*LANE_W +: LANE_W];
         endcase
      end
   end

endmodule

// File: rtl/apx_inbound_xlate.sv
module apx_inbound_xlate
   import apx_pkg::*;
#(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned BASE_W        = 24,
   parameter int unsigned SIZE_W        = 4,
   parameter int unsigned MEM_MIN_SHIFT = 20,
   parameter int unsigned IO_MIN_SHIFT  = 8,
   localparam int unsigned LANES = DATA_W / 8,
   localparam int unsigned CFG_W = BASE_W + SIZE_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic              cfg_error,
   input  logic              req_valid,
   input  logic              req_io,
   input  logic              req_wr,
   input  logic              req_first,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LANES-1:0]  req_be,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              loc_valid,
   output logic              loc_wr,
   output logic [ADDR_W-1:0] loc_addr,
   output logic [LANES-1:0]  loc_be,
   output logic [DATA_W-1:0] loc_wdata,
   output logic              retry_ok,
   input  logic [DATA_W-1:0] lcl_rdata,
   output logic [DATA_W-1:0] hst_rdata
);
   localparam int unsigned SHW = $clog2(ADDR_W + 1);

   if (DATA_W != 32) begin : g_bad_data
      $error("apx_inbound_xlate: automatic swap decode needs four byte lanes");
   end
   if (MEM_MIN_SHIFT + (1 << SIZE_W) > ADDR_W + 16) begin : g_bad_shift
      $error("apx_inbound_xlate: aperture range exceeds the address width");
   end

   // ---------------- map register ----------------
   logic [BASE_W-1:0] map_base;
   logic [SIZE_W-1:0] map_size;
   swap_mode_e        map_swap;
   logic              map_rpd;

   apx_map_reg #(.BASE_W(BASE_W), .SIZE_W(SIZE_W)) map_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .base_o(map_base),
      .size_o(map_size),
      .swap_o(map_swap),
      .rpd_o (map_rpd)
   );

   // ---------------- address path ----------------
   logic [SHW-1:0]    shift;
   logic              size_reserved;
   logic [ADDR_W-1:0] addr_x;

   apx_shift_dec #(
      .SIZE_W       (SIZE_W),
      .SHW          (SHW),
      .MEM_MIN_SHIFT(MEM_MIN_SHIFT),
      .IO_MIN_SHIFT (IO_MIN_SHIFT)
   ) dec_i (
      .size_i    (map_size),
      .io_i      (req_io),
      .shift_o   (shift),
      .reserved_o(size_reserved)
   );

   apx_addr_map #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .SHW(SHW)) amap_i (
      .base_i (map_base),
      .shift_i(shift),
      .host_i (req_addr),
      .loc_o  (addr_x)
   );

   assign cfg_error = size_reserved;

   // ---------------- lane swap ----------------
   swap_mode_e        wr_mode;
   swap_mode_e        rd_mode;
   logic [DATA_W-1:0] wdata_x;
   logic [LANES-1:0]  be_x;
   logic [LANES-1:0]  held_be_q;

   assign wr_mode = resolve_swap(map_swap, req_be);
   assign rd_mode = resolve_swap(map_swap, held_be_q);

   apx_lane_swap #(.LANE_W(8), .LANES(LANES)) wswap_i (
      .mode_i(wr_mode),
      .din   (req_wdata),
      .dout  (wdata_x)
   );

   apx_lane_swap #(.LANE_W(1), .LANES(LANES)) bswap_i (
      .mode_i(wr_mode),
      .din   (req_be),
      .dout  (be_x)
   );

   apx_lane_swap #(.LANE_W(8), .LANES(LANES)) rswap_i (
      .mode_i(rd_mode),
      .din   (lcl_rdata),
      .dout  (hst_rdata)
   );

   // ---------------- output stage ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loc_valid <= 1'b0;
         loc_wr    <= 1'b0;
         loc_addr  <= '0;
         loc_be    <= '0;
         loc_wdata <= '0;
         retry_ok  <= 1'b0;
         held_be_q <= '0;
      end else begin
         loc_valid <= req_valid;
         if (req_valid) begin
            loc_wr    <= req_wr;
            loc_addr  <= addr_x;
            loc_be    <= be_x;
            loc_wdata <= wdata_x;
            retry_ok  <= !(map_rpd && !req_wr && req_first);
            held_be_q <= req_be;
         end
      end
   end

endmodule

// File: rtl/apx_inbound_xlate_chk.sv
module apx_inbound_xlate_chk #(
   parameter int unsigned MEM_MIN_SHIFT = 20
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_io,
   input logic        req_wr,
   input logic        req_first,
   input logic [31:0] req_addr,
   input logic [3:0]  req_be,
   input logic [31:0] req_wdata,
   input logic        loc_valid,
   input logic [31:0] loc_addr,
   input logic [3:0]  loc_be,
   input logic [31:0] loc_wdata,
   input logic        retry_ok,
   input logic [1:0]  map_swap,
   input logic        map_rpd
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> loc_valid); // R2
   AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !loc_valid); // R2
   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) loc_valid |-> loc_addr[1:0] == 2'b00); // R6
   AST_MEM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_io) |=> loc_addr[MEM_MIN_SHIFT-1:2] == $past(req_addr[MEM_MIN_SHIFT-1:2])); // R3
   AST_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && map_swap == 2'b00) |=> (loc_wdata == $past(req_wdata) && loc_be == $past(req_be))); // R7
   AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> $countones(loc_be) == $countones($past(req_be))); // R10
   AST_RPD_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && map_rpd && !req_wr && req_first) |=> !retry_ok); // R11
   AST_RETRY_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !map_rpd) |=> retry_ok); // R11
endmodule

bind apx_inbound_xlate apx_inbound_xlate_chk #(.MEM_MIN_SHIFT(MEM_MIN_SHIFT)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_io   (req_io),
   .req_wr   (req_wr),
   .req_first(req_first),
   .req_addr (req_addr),
   .req_be   (req_be),
   .req_wdata(req_wdata),
   .loc_valid(loc_valid),
   .loc_addr (loc_addr),
   .loc_be   (loc_be),
   .loc_wdata(loc_wdata),
   .retry_ok (retry_ok),
   .map_swap (map_swap),
   .map_rpd  (map_rpd)
);

// File: tb/apx_inbound_xlate_tb_top.sv
module apx_inbound_xlate_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [30:0] cfg_wdata = '0;
   logic        cfg_error;
   logic        req_valid = 1'b0;
   logic        req_io = 1'b0;
   logic        req_wr = 1'b0;
   logic        req_first = 1'b0;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        loc_valid;
   logic        loc_wr;
   logic [31:0] loc_addr;
   logic [3:0]  loc_be;
   logic [31:0] loc_wdata;
   logic        retry_ok;
   logic [31:0] lcl_rdata = '0;
   logic [31:0] hst_rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   apx_inbound_xlate dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_error(cfg_error),
      .req_valid(req_valid), .req_io(req_io), .req_wr(req_wr), .req_first(req_first),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .loc_valid(loc_valid), .loc_wr(loc_wr), .loc_addr(loc_addr), .loc_be(loc_be),
      .loc_wdata(loc_wdata), .retry_ok(retry_ok), .lcl_rdata(lcl_rdata), .hst_rdata(hst_rdata)
   );

   typedef struct packed {
      logic [3:0]  rq;
      logic [23:0] base;
      logic [3:0]  size;
      logic [1:0]  swap;
      logic        rpd;
      logic        io;
      logic        wr;
      logic        first;
      logic [3:0]  be;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic [31:0] eaddr;
      logic [3:0]  ebe;
      logic [31:0] ewdata;
      logic        eretry;
      logic        eerr;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      // R3 R6 1MB, no swap, unaligned host address
      '{4'd3, 24'hABC000, 4'h0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 4'hF, 32'h1234567B, 32'h11223344, 32'hABC45678, 4'hF, 32'h11223344, 1'b1, 1'b0},
      // R3 R8 16MB, halfword swap
      '{4'd8, 24'hABCDEF, 4'h4, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 4'b1100, 32'h12345679, 32'h11223344, 32'hAB345678, 4'b0011, 32'h33441122, 1'b1, 1'b0},
      // R4 R9 I/O 512B, byte reversal
      '{4'd9, 24'hABCDEF, 4'h5, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0110, 32'h123456FF, 32'h11223344, 32'hABCDEEFC, 4'b0110, 32'h44332211, 1'b1, 1'b0},
      // R5 reserved 1011 memory
      '{4'd5, 24'hABCDEF, 4'hB, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 4'hF, 32'h12345678, 32'h55667788, 32'hABC45678, 4'hF, 32'h55667788, 1'b1, 1'b1},
      // R5 reserved 1100 on I/O
      '{4'd5, 24'h123456, 4'hC, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 32'hFFFFFFFF, 32'h55667788, 32'h123FFFFC, 4'hF, 32'h55667788, 1'b1, 1'b1},
      // R10 auto, 0011 -> halfword; R3 2MB
      '{4'd10, 24'hFFF000, 4'h1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0011, 32'h00312344, 32'hAABBCCDD, 32'hFFF12344, 4'b1100, 32'hCCDDAABB, 1'b1, 1'b0},
      // R10 auto, 1110 -> byte reversal
      '{4'd10, 24'h000000, 4'h0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 4'b1110, 32'h00000010, 32'hAABBCCDD, 32'h00000010, 4'b0111, 32'hDDCCBBAA, 1'b1, 1'b0},
      // R10 auto, 0101 -> no swap
      '{4'd10, 24'h000000, 4'h0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0101, 32'h00000020, 32'hAABBCCDD, 32'h00000020, 4'b0101, 32'hAABBCCDD, 1'b1, 1'b0},
      // R11 first read with read-post-disable
      '{4'd11, 24'h000000, 4'h0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 32'h00000040, 32'h0, 32'h00000040, 4'hF, 32'h0, 1'b0, 1'b0},
      // R11 later read with read-post-disable
      '{4'd11, 24'h000000, 4'h0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 32'h00000044, 32'h0, 32'h00000044, 4'hF, 32'h0, 1'b1, 1'b0},
      // R11 first write with read-post-disable
      '{4'd11, 24'h000000, 4'h0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 32'h00000048, 32'h01020304, 32'h00000048, 4'hF, 32'h01020304, 1'b1, 1'b0},
      // R3 1GB top code
      '{4'd3, 24'hC00000, 4'hA, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 4'hF, 32'h3FFFFFFF, 32'h01020304, 32'hFFFFFFFC, 4'hF, 32'h01020304, 1'b1, 1'b0},
      // R4 I/O 2KB top I/O code
      '{4'd4, 24'hABCDEF, 4'h7, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 32'h12345FFF, 32'h01020304, 32'hABCDEFFC, 4'hF, 32'h01020304, 1'b1, 1'b0},
      // R4 I/O with a memory-only code keeps memory mapping
      '{4'd4, 24'hABCDEF, 4'h0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 32'h12345678, 32'h01020304, 32'hABC45678, 4'hF, 32'h01020304, 1'b1, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic cfg_write(input logic [23:0] b, input logic [3:0] s, input logic [1:0] w, input logic r);
      cfg_we = 1'b1;
      cfg_wdata = {b, s, w, r};
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send(input logic io, input logic wr, input logic first, input logic [3:0] be,
                       input logic [31:0] a, input logic [31:0] d);
      req_valid = 1'b1;
      req_io = io;
      req_wr = wr;
      req_first = first;
      req_be = be;
      req_addr = a;
      req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 loc_valid in reset", 32'(loc_valid), 32'd0);
      check("R1 cfg_error in reset", 32'(cfg_error), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 loc_valid after reset", 32'(loc_valid), 32'd0);
      send(1'b0, 1'b0, 1'b1, 4'b1100, 32'hFEDCBA98, 32'h11223344);
      check("R1 addr with zero map", loc_addr, 32'h000CBA98);
      check("R1 no swap after reset", loc_wdata, 32'h11223344);
      check("R1 be after reset", 32'(loc_be), 32'h0000000C);
      check("R1 retry after reset", 32'(retry_ok), 32'd1);
      check("R2 valid one cycle later", 32'(loc_valid), 32'd1);
      check("R2 direction registered", 32'(loc_wr), 32'd0);
      @(negedge clk);
      check("R2 valid drops when idle", 32'(loc_valid), 32'd0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         cfg_write(VEC[i].base, VEC[i].size, VEC[i].swap, VEC[i].rpd);
         check($sformatf("R5 cfg_error vec %0d (R%0d)", i, VEC[i].rq), 32'(cfg_error), 32'(VEC[i].eerr));
         send(VEC[i].io, VEC[i].wr, VEC[i].first, VEC[i].be, VEC[i].addr, VEC[i].wdata);
         check($sformatf("R2 valid vec %0d", i), 32'(loc_valid), 32'd1);
         check($sformatf("R2 wr vec %0d", i), 32'(loc_wr), 32'(VEC[i].wr));
         check($sformatf("R%0d addr vec %0d", VEC[i].rq, i), loc_addr, VEC[i].eaddr);
         check($sformatf("R%0d be vec %0d", VEC[i].rq, i), 32'(loc_be), 32'(VEC[i].ebe));
         check($sformatf("R%0d wdata vec %0d", VEC[i].rq, i), loc_wdata, VEC[i].ewdata);
         check($sformatf("R%0d retry vec %0d", VEC[i].rq, i), 32'(retry_ok), 32'(VEC[i].eretry));
      end

      // R13 write and request in the same cycle
      cfg_write(24'h000000, 4'h0, 2'b00, 1'b0);
      cfg_we = 1'b1;
      cfg_wdata = {24'hABC000, 4'h0, 2'b01, 1'b0};
      send(1'b0, 1'b1, 1'b0, 4'hF, 32'h12345678, 32'h11223344);
      cfg_we = 1'b0;
      check("R13 old map address", loc_addr, 32'h00045678);
      check("R13 old map swap", loc_wdata, 32'h11223344);
      send(1'b0, 1'b1, 1'b0, 4'hF, 32'h12345678, 32'h11223344);
      check("R13 new map address", loc_addr, 32'hABC45678);
      check("R13 new map swap", loc_wdata, 32'h33441122);

      // R12 read return path
      cfg_write(24'h000000, 4'h0, 2'b10, 1'b0);
      send(1'b0, 1'b0, 1'b0, 4'hF, 32'h00000100, 32'h0);
      lcl_rdata = 32'h01020304;
      #1;
      check("R12 read byte reversal", hst_rdata, 32'h04030201);
      @(negedge clk);
      cfg_write(24'h000000, 4'h0, 2'b11, 1'b0);
      send(1'b0, 1'b0, 1'b0, 4'b1100, 32'h00000104, 32'h0);
      #1;
      check("R12 read auto halfword", hst_rdata, 32'h03040102);
      @(negedge clk);
      send(1'b0, 1'b0, 1'b0, 4'b0101, 32'h00000108, 32'h0);
      #1;
      check("R12 read auto none", hst_rdata, 32'h01020304);
      @(negedge clk);
      cfg_write(24'h000000, 4'h0, 2'b00, 1'b0);
      #1;
      check("R12 read pass-through", hst_rdata, 32'h01020304);
      check("R5 cfg_error clear on valid code", 32'(cfg_error), 32'd0);

      @(negedge clk);
      finish_run();
   end

endmodule